// File: doc/BRIEF.md
# Prescaled Counter with Compare Events

This block is a timekeeping counter advanced by a tick taken from a free-running binary divider. Software picks one of two counting configurations: a full-width count with one compare value and an optional return to zero on match, or a half-width count that wraps at a programmable period and is watched by two compare values. Eight taps on the divider give periodic-interval flags. Every condition sets a sticky flag, can raise the shared interrupt line when its enable is set, and can emit a one-cycle event pulse when its event enable is set.

All configuration goes through a single-cycle write port and a combinational read port. Register map, by word address: 0 control, 1 event enables, 2 interrupt-enable clear, 3 interrupt-enable set, 4 flags, 5 count, 6 period, 7 compare 0, 8 compare 1. Control fields: bit 0 software reset (write-only, reads 0), bit 1 enable, bits 3:2 mode (0 full-width, 1 half-width, 2 and 3 do not count), bit 7 clear on match, bits 11:8 divider code, bit 16 keep running while the debug halt input is high. Flag, interrupt-enable and event-enable bits share one layout: bits 0 to 7 periodic intervals 0 to 7, bit 8 compare 0, bit 9 compare 1, bit 15 overflow.

Top module: `prescaled_cmp_counter`

## Requirements
- R1: After the reset input, or after a write to address 0 with bit 0 set, every register reads 0, the block is disabled, and bit 0 of address 0 always reads 0.
- R2: With divider code 0 or 1 the count advances every enabled cycle; code c from 2 to 11 advances it once per 2^(c-1) cycles; codes 12 to 15 behave as code 11; the divider restarts from zero when the block is enabled.
- R3: The count changes only on a tick or a write to address 5; no tick occurs while the enable bit is clear or while the mode field is 2 or 3.
- R4: In full-width mode a tick at the all-ones count gives zero and sets flag bit 15.
- R5: A tick at which the count equals compare 0 sets flag bit 8; in full-width mode with clear on match set, that tick loads zero and also sets flag bit 15.
- R6: In half-width mode a tick at a count equal to the period gives zero and sets bit 15, compare 1 equality sets bit 9, and the upper half of the count is held at zero, also on writes to address 5.
- R7: Periodic interval n sets flag bit n when divider stage 7-n rises, first 2^(7-n) cycles after enabling with the count running every cycle.
- R8: Writing 1 to a flag bit clears it and 0 leaves it; a hardware set in the same cycle as the clear leaves the flag set.
- R9: Writing 1 to address 3 sets and to address 2 clears interrupt-enable bits, both addresses read the enable mask, and irq is high while any flag and its enable are both set.
- R10: evt_out bit n pulses for one cycle, in the cycle the flag bit n is set, only when event enable bit n is set.
- R11: While dbg_halt is high and control bit 16 is clear, the count and divider stop; with bit 16 set they run.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| dbg_halt | input | 1 | Debug halt request |
| evt_out | output | 16 | Event pulses, flag layout |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag clear landing in the very edge where hardware sets the same flag, since the set must win. The stimulus enables the block at divide-by-1, where periodic interval 7 rises on every odd cycle after enabling, counts edges from the enabling write, and issues one clear on an even edge (which must clear) and one on the next odd edge (where the flag must stay set). Overflow from all ones is reached by loading the count two below wrap, and the slowest periodic tap by waiting exactly 127 and 128 cycles.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   localparam int DATA_W = 32;
   localparam int ADDR_W = 4;
   localparam int FLAG_W = 16;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL   = 4'd0,
      A_EVEN   = 4'd1,
      A_IECLR  = 4'd2,
      A_IESET  = 4'd3,
      A_FLAG   = 4'd4,
      A_COUNT  = 4'd5,
      A_PERIOD = 4'd6,
      A_CMP0   = 4'd7,
      A_CMP1   = 4'd8
   } reg_addr_e;

   typedef enum logic [1:0] {
      M_WIDE = 2'd0,
      M_HALF = 2'd1,
      M_CAL  = 2'd2,
      M_RSV  = 2'd3
   } cnt_mode_e;

   // control field positions
   localparam int B_SWRST  = 0;
   localparam int B_EN     = 1;
   localparam int B_MODE   = 2;
   localparam int B_MCLR   = 7;
   localparam int B_PSC    = 8;
   localparam int B_DBGRUN = 16;

   // flag positions
   localparam int F_CMP0 = 8;
   localparam int F_CMP1 = 9;
   localparam int F_OVF  = 15;

endpackage

// File: rtl/pcc_prescaler.sv
module pcc_prescaler #(
   parameter int STAGES   = 10,
   parameter int NUM_TAPS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                run,
   input  logic [3:0]          code,
   output logic                tick,
   output logic [NUM_TAPS-1:0] tap_rise
);

   localparam int MAX_SHIFT = 10;

   logic [STAGES-1:0] div_q;
   logic [STAGES-1:0] tick_mask;
   int unsigned       shift;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     div_q <= '0;
      else if (clear) div_q <= '0;
      else if (run)   div_q <= div_q + 1'b1;
   end

   always_comb begin
      if (code <= 4'd1)       shift = 0;
      else if (code <= 4'd11) shift = 32'(code) - 32'd1;
      else                    shift = MAX_SHIFT;
      tick_mask = STAGES'((64'd1 << shift) - 64'd1);
   end

   assign tick = run && ((div_q & tick_mask) == tick_mask);

   // tap n watches stage NUM_TAPS-1-n: it rises when the low bits below it
   // are all ones and the stage itself is still zero
   for (genvar n = 0; n < NUM_TAPS; n++) begin : g_tap
      localparam int               S   = NUM_TAPS - 1 - n;
      localparam logic [STAGES-1:0] LOW = STAGES'((64'd1 << S) - 64'd1);
      localparam logic [STAGES-1:0] SEL = STAGES'((64'd1 << (S + 1)) - 64'd1);
      assign tap_rise[n] = run && ((div_q & SEL) == LOW);
   end

   p_taps_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tap_rise));

   p_fast_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && code <= 4'd1) |-> tick);

   p_frozen_divider_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(div_q));

endmodule

// File: rtl/pcc_counter.sv
module pcc_counter #(
   parameter int CNT_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    srst,
   input  logic                    tick,
   input  logic                    half_mode,
   input  logic                    match_clr,
   input  logic                    load,
   input  logic [CNT_W-1:0]        load_val,
   input  logic [CNT_W/2-1:0]      period,
   input  logic [CNT_W-1:0]        cmp0,
   input  logic [CNT_W/2-1:0]      cmp1,
   output logic [CNT_W-1:0]        count_q,
   output logic                    hit_cmp0,
   output logic                    hit_cmp1,
   output logic                    hit_ovf
);

   localparam int HALF_W = CNT_W / 2;
   localparam int UP_W   = CNT_W - HALF_W;

   logic [HALF_W-1:0] lo;
   logic [CNT_W-1:0]  next_cnt;
   logic [CNT_W-1:0]  load_eff;
   logic              eq0;
   logic              wrap;

   assign lo = count_q[HALF_W-1:0];

   always_comb begin
      if (half_mode) begin
         eq0      = (lo == cmp0[HALF_W-1:0]);
         wrap     = (lo == period);
         hit_cmp1 = tick && (lo == cmp1);
         next_cnt = wrap ? '0 : {{UP_W{1'b0}}, lo + 1'b1};
         load_eff = {{UP_W{1'b0}}, load_val[HALF_W-1:0]};
      end else begin
         eq0      = (count_q == cmp0);
         wrap     = (&count_q) || (match_clr && eq0);
         hit_cmp1 = 1'b0;
         next_cnt = (match_clr && eq0) ? '0 : count_q + 1'b1;
         load_eff = load_val;
      end
      hit_cmp0 = tick && eq0;
      hit_ovf  = tick && wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_q <= '0;
      else if (srst)  count_q <= '0;
      else if (load)  count_q <= load_eff;
      else if (tick)  count_q <= next_cnt;
   end

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load && !srst) |=> $stable(count_q));

   p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ovf && !load && !srst) |=> (count_q == '0));

   p_half_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (half_mode && (tick || load)) |=> (count_q[CNT_W-1:HALF_W] == '0));

endmodule

// File: rtl/pcc_flags.sv
module pcc_flags #(
   parameter int                FLAG_W = 16,
   parameter logic [FLAG_W-1:0] VALID  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic [FLAG_W-1:0] set_mask,
   input  logic              clr_we,
   input  logic              ie_set_we,
   input  logic              ie_clr_we,
   input  logic              ev_we,
   input  logic [FLAG_W-1:0] wdata,
   output logic [FLAG_W-1:0] flags_q,
   output logic [FLAG_W-1:0] inten_q,
   output logic [FLAG_W-1:0] evctrl_q,
   output logic [FLAG_W-1:0] evt_q,
   output logic              irq
);

   logic [FLAG_W-1:0] clr_mask;

   assign clr_mask = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q  <= '0;
         inten_q  <= '0;
         evctrl_q <= '0;
         evt_q    <= '0;
      end else if (srst) begin
         flags_q  <= '0;
         inten_q  <= '0;
         evctrl_q <= '0;
         evt_q    <= '0;
      end else begin
         flags_q <= ((flags_q & ~clr_mask) | set_mask) & VALID;
         if (ie_set_we) inten_q <= inten_q | (wdata & VALID);
         if (ie_clr_we) inten_q <= inten_q & ~wdata;
         if (ev_we)     evctrl_q <= wdata & VALID;
         evt_q <= set_mask & evctrl_q;
      end
   end

   assign irq = |(flags_q & inten_q);

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !srst |=> ((flags_q & $past(set_mask & VALID)) == $past(set_mask & VALID)));

   p_evt_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & ~$past(evctrl_q)) == '0));

endmodule

// File: rtl/prescaled_cmp_counter.sv
module prescaled_cmp_counter
   import pcc_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int DIV_STAGES = 10,
   parameter int NUM_PER    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              dbg_halt,
   output logic [FLAG_W-1:0] evt_out,
   output logic              irq
);

   localparam int HALF_W = CNT_W / 2;
   localparam logic [FLAG_W-1:0] FLAG_VALID =
      FLAG_W'((64'd1 << NUM_PER) - 64'd1) |
      (FLAG_W'(1) << F_CMP0) | (FLAG_W'(1) << F_CMP1) | (FLAG_W'(1) << F_OVF);

   if (CNT_W % 2 != 0 || CNT_W < 4 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must be even and between 4 and the data width");
   end
   if (NUM_PER < 1 || NUM_PER > 8 || NUM_PER > DIV_STAGES) begin : g_bad_num_per
      $error("NUM_PER must be 1..8 and not exceed DIV_STAGES");
   end
   if (DIV_STAGES < 10) begin : g_bad_stages
      $error("DIV_STAGES must cover the largest divider code");
   end

   // control state
   logic        en_q;
   cnt_mode_e   mode_q;
   logic        mclr_q;
   logic [3:0]  psc_q;
   logic        dbgrun_q;
   logic [HALF_W-1:0] period_q;
   logic [CNT_W-1:0]  cmp0_q;
   logic [HALF_W-1:0] cmp1_q;

   logic srst;
   logic run;
   logic tick;
   logic half_mode;
   logic [NUM_PER-1:0] taps;
   logic [CNT_W-1:0]   count_q;
   logic hit_cmp0, hit_cmp1, hit_ovf;
   logic [FLAG_W-1:0] set_mask, flags_q, inten_q, evctrl_q;

   function automatic logic wr_hit(input logic en, input logic [ADDR_W-1:0] a,
                                   input reg_addr_e want);
      return en && (a == want);
   endfunction

   assign srst      = wr_hit(wr_en, wr_addr, A_CTRL) && wr_data[B_SWRST];
   assign half_mode = (mode_q == M_HALF);
   assign run       = en_q && (mode_q == M_WIDE || mode_q == M_HALF) &&
                      !(dbg_halt && !dbgrun_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || srst) begin
         en_q     <= 1'b0;
         mode_q   <= M_WIDE;
         mclr_q   <= 1'b0;
         psc_q    <= '0;
         dbgrun_q <= 1'b0;
         period_q <= '0;
         cmp0_q   <= '0;
         cmp1_q   <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            A_CTRL: begin
               en_q     <= wr_data[B_EN];
               mode_q   <= cnt_mode_e'(wr_data[B_MODE +: 2]);
               mclr_q   <= wr_data[B_MCLR];
               psc_q    <= wr_data[B_PSC +: 4];
               dbgrun_q <= wr_data[B_DBGRUN];
            end
            A_PERIOD: period_q <= wr_data[HALF_W-1:0];
            A_CMP0:   cmp0_q   <= wr_data[CNT_W-1:0];
            A_CMP1:   cmp1_q   <= wr_data[HALF_W-1:0];
            default: ;
         endcase
      end
   end

   pcc_prescaler #(
      .STAGES   (DIV_STAGES),
      .NUM_TAPS (NUM_PER)
   ) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (srst || !en_q),
      .run      (run),
      .code     (psc_q),
      .tick     (tick),
      .tap_rise (taps)
   );

   pcc_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (srst),
      .tick      (tick),
      .half_mode (half_mode),
      .match_clr (mclr_q),
      .load      (wr_hit(wr_en, wr_addr, A_COUNT)),
      .load_val  (wr_data[CNT_W-1:0]),
      .period    (period_q),
      .cmp0      (cmp0_q),
      .cmp1      (cmp1_q),
      .count_q   (count_q),
      .hit_cmp0  (hit_cmp0),
      .hit_cmp1  (hit_cmp1),
      .hit_ovf   (hit_ovf)
   );

   always_comb begin
      set_mask              = '0;
      set_mask[NUM_PER-1:0] = taps;
      set_mask[F_CMP0]      = hit_cmp0;
      set_mask[F_CMP1]      = hit_cmp1;
      set_mask[F_OVF]       = hit_ovf;
   end

   pcc_flags #(
      .FLAG_W (FLAG_W),
      .VALID  (FLAG_VALID)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (srst),
      .set_mask  (set_mask),
      .clr_we    (wr_hit(wr_en, wr_addr, A_FLAG)),
      .ie_set_we (wr_hit(wr_en, wr_addr, A_IESET)),
      .ie_clr_we (wr_hit(wr_en, wr_addr, A_IECLR)),
      .ev_we     (wr_hit(wr_en, wr_addr, A_EVEN)),
      .wdata     (wr_data[FLAG_W-1:0]),
      .flags_q   (flags_q),
      .inten_q   (inten_q),
      .evctrl_q  (evctrl_q),
      .evt_q     (evt_out),
      .irq       (irq)
   );

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL: begin
            rd_data[B_EN]        = en_q;
            rd_data[B_MODE +: 2] = mode_q;
            rd_data[B_MCLR]      = mclr_q;
            rd_data[B_PSC +: 4]  = psc_q;
            rd_data[B_DBGRUN]    = dbgrun_q;
         end
         A_EVEN:   rd_data = DATA_W'(evctrl_q);
         A_IECLR,
         A_IESET:  rd_data = DATA_W'(inten_q);
         A_FLAG:   rd_data = DATA_W'(flags_q);
         A_COUNT:  rd_data = DATA_W'(count_q);
         A_PERIOD: rd_data = DATA_W'(period_q);
         A_CMP0:   rd_data = DATA_W'(cmp0_q);
         A_CMP1:   rd_data = DATA_W'(cmp1_q);
         default:  rd_data = '0;
      endcase
   end

endmodule

// File: tb/prescaled_cmp_counter_tb.sv
module prescaled_cmp_counter_tb;
   import pcc_pkg::*;

   localparam int CLK_P = 10;
   localparam int NVEC  = 8;
   // divider code, enabled cycles
   localparam int VEC [NVEC][2] = '{
      '{0, 10}, '{1, 10}, '{2, 11}, '{3, 13},
      '{4, 40}, '{6, 100}, '{11, 2050}, '{14, 1030}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        dbg_halt = 1'b0;
   logic [15:0] evt_out;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   prescaled_cmp_counter u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .dbg_halt(dbg_halt), .evt_out(evt_out), .irq(irq)
   );

   localparam logic [31:0] EN   = 32'h2;
   localparam logic [31:0] MCLR = 32'h80;
   localparam logic [31:0] HALF = 32'h4;
   localparam logic [31:0] CAL  = 32'h8;
   localparam logic [31:0] DRUN = 32'h1_0000;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int psc_shift(input int c);
      if (c <= 1)       return 0;
      else if (c <= 11) return c - 1;
      else              return 10;
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      rd(A_CTRL, v);  chk("R1 ctrl after reset", v, 0);
      rd(A_COUNT, v); chk("R1 count after reset", v, 0);
      rd(A_FLAG, v);  chk("R1 flags after reset", v, 0);
      chk("R1 irq/evt after reset", {15'd0, irq, evt_out}, 0);

      // R2 divider codes
      for (int i = 0; i < NVEC; i++) begin
         wr(A_COUNT, 0);
         wr(A_CTRL, EN | (32'(VEC[i][0]) << 8));
         cyc(VEC[i][1]);
         rd(A_COUNT, v);
         chk($sformatf("R2 code %0d count", VEC[i][0]), v,
             32'(VEC[i][1] >> psc_shift(VEC[i][0])));
         wr(A_CTRL, 0);
      end

      // R3 disabled and unsupported mode hold the count
      wr(A_COUNT, 7);
      cyc(20);
      rd(A_COUNT, v); chk("R3 disabled hold", v, 7);
      wr(A_CTRL, EN | CAL);
      cyc(20);
      rd(A_COUNT, v); chk("R3 mode 2 hold", v, 7);
      wr(A_CTRL, 0);

      // R7 slowest tap
      wr(A_FLAG, 32'hFFFF);
      wr(A_COUNT, 0);
      wr(A_CTRL, EN);
      cyc(127);
      rd(A_FLAG, v); chk("R7 taps 0/1 at 127", {30'd0, v[1:0]}, 32'b10);
      cyc(1);
      rd(A_FLAG, v); chk("R7 tap 0 at 128", {31'd0, v[0]}, 1);
      wr(A_CTRL, 0);

      // R8 write-one-to-clear and set-wins
      wr(A_FLAG, 32'hFFFF);
      wr(A_CTRL, EN);
      cyc(3);
      wr(A_FLAG, 32'h80);
      rd(A_FLAG, v); chk("R8 clear bit7 only", {30'd0, v[7:6]}, 32'b01);
      wr(A_FLAG, 32'h80);
      rd(A_FLAG, v); chk("R8 set wins over clear", {31'd0, v[7]}, 1);
      wr(A_CTRL, 0);

      // R5 clear on match
      wr(A_COUNT, 0);
      wr(A_CMP0, 5);
      wr(A_FLAG, 32'hFFFF);
      wr(A_CTRL, EN | MCLR);
      cyc(5);
      rd(A_COUNT, v); chk("R5 count reaches compare", v, 5);
      rd(A_FLAG, v);  chk("R5 no flag before match tick", {31'd0, v[8]}, 0);
      cyc(1);
      rd(A_COUNT, v); chk("R5 cleared on match", v, 0);
      rd(A_FLAG, v);  chk("R5 cmp0 and ovf flags", {30'd0, v[15], v[8]}, 32'b11);

      // R9 interrupt enables
      chk("R9 irq low without enables", {31'd0, irq}, 0);
      wr(A_IESET, 32'h100);
      chk("R9 irq high", {31'd0, irq}, 1);
      rd(A_IECLR, v); chk("R9 enable readback", v, 32'h100);
      wr(A_IECLR, 32'h100);
      chk("R9 irq low after clear", {31'd0, irq}, 0);
      wr(A_CTRL, 0);

      // R4 and R10 full-width wrap with event
      wr(A_CMP0, 32'h10);
      wr(A_COUNT, 32'hFFFF_FFFE);
      wr(A_FLAG, 32'hFFFF);
      wr(A_EVEN, 32'h8000);
      wr(A_CTRL, EN);
      cyc(1);
      rd(A_COUNT, v); chk("R4 all ones", v, 32'hFFFF_FFFF);
      rd(A_FLAG, v);  chk("R4 no ovf yet", {31'd0, v[15]}, 0);
      cyc(1);
      rd(A_COUNT, v); chk("R4 wrapped", v, 0);
      rd(A_FLAG, v);  chk("R4 ovf flag", {31'd0, v[15]}, 1);
      chk("R10 ovf event only", {16'd0, evt_out}, 32'h8000);
      cyc(1);
      chk("R10 event one cycle", {16'd0, evt_out}, 0);
      wr(A_CTRL, 0);

      // R6 half-width mode
      wr(A_COUNT, 0);
      wr(A_PERIOD, 4);
      wr(A_CMP0, 2);
      wr(A_CMP1, 3);
      wr(A_FLAG, 32'hFFFF);
      wr(A_CTRL, EN | HALF);
      cyc(3);
      rd(A_FLAG, v); chk("R6 cmp0 set, cmp1 not", {30'd0, v[9:8]}, 32'b01);
      cyc(1);
      rd(A_COUNT, v); chk("R6 count at period", v, 4);
      rd(A_FLAG, v);  chk("R6 cmp1 set, no ovf", {29'd0, v[15], v[9:8]}, 32'b011);
      cyc(1);
      rd(A_COUNT, v); chk("R6 wrap at period", v, 0);
      rd(A_FLAG, v);  chk("R6 ovf flag", {31'd0, v[15]}, 1);
      wr(A_CTRL, HALF);
      wr(A_COUNT, 32'hABCD_1234);
      rd(A_COUNT, v); chk("R6 upper half zero on load", v, 32'h0000_1234);

      // R11 debug halt
      dbg_halt = 1'b1;
      wr(A_COUNT, 0);
      wr(A_CTRL, EN);
      cyc(10);
      rd(A_COUNT, v); chk("R11 halted", v, 0);
      wr(A_CTRL, EN | DRUN);
      cyc(10);
      rd(A_COUNT, v); chk("R11 runs in debug", v, 10);
      dbg_halt = 1'b0;

      // R1 software reset
      wr(A_IESET, 32'h8000);
      wr(A_CTRL, EN | 32'h1);
      rd(A_CTRL, v);  chk("R1 ctrl after soft reset", v, 0);
      rd(A_COUNT, v); chk("R1 count after soft reset", v, 0);
      rd(A_CMP0, v);  chk("R1 cmp0 after soft reset", v, 0);
      rd(A_IESET, v); chk("R1 enables after soft reset", v, 0);
      cyc(5);
      rd(A_COUNT, v); chk("R1 stays disabled", v, 0);
      rd(A_FLAG, v);  chk("R1 flags after soft reset", {15'd0, irq, v[15:0]}, 0);

      summary();
      $finish;
   end

endmodule